// File: doc/BRIEF.md
# Command Packet Framer

This block sits between a host that writes 32-bit command words one at a time and a rendering back end that wants whole commands. It collects words into a local buffer. It reads the opcode from the top byte of the first word and works out how long the command is. When every word of the command has arrived, it replays the packet word by word on a valid/ready output. Each output word carries first and last markers, the opcode, the packet length and a kind code.

Most opcodes have a fixed length. The length is one header word plus a parameter count that depends on the opcode. Polyline opcodes have no fixed length: they end at the first eligible word that matches a masked sentinel. A command may arrive in pieces with idle gaps between words. The partial words wait in the buffer until the command is complete.

Two groups of opcodes are consumed on the spot and never reach the output. Environment-setting opcodes write the whole word into an internal bank of eight registers, and selected bits of two of those registers form a status word. The other is a no-operation opcode.

Top module: `cmd_packet_framer`

## Requirements
- R1: After reset, inReady is 1, outValid is 0, overflowPulse is 0 and statusWord is 0. Environment register i reads back as {8'hE0+i, 24'h0} on envData.
- R2: Fixed-length packets are emitted only after all their words have arrived, in arrival order, with outFirst on word 0 and outLast on the final word. The packet length is 1 plus a parameter count, for example:
  - 0x00: 1
  - 0x02: 3
  - 0x20: 4
  - 0x24: 7
  - 0x2C: 9
  - 0x3C: 12
  - 0x64: 4
- R3: The outKind code is 2 for opcodes 0x80–0x9F, which are 4-word packets. It is 1 for opcodes 0xA0–0xDF, which are 3-word packets. It is 0 for every other emitted opcode.
- R4: A flat polyline (opcodes 0x48–0x4F) ends at the first word at index 3 or higher whose value ANDed with 0xF000F000 equals 0x50005000. The packet includes that word. A matching word at index 1 or 2 does not end the packet.
- R5: A shaded polyline (opcodes 0x58–0x5F) tests for the same sentinel only at even indices from 4 upward. A matching word at an odd index is kept as ordinary data.
- R6: A word with opcode 0xE0–0xE7 is stored whole into environment register opcode[2:0] and is not emitted.
- R7: A word with opcode 0x1F is consumed alone and emits nothing. The next word starts a fresh packet.
- R8: statusWord[10:0] equals bits [10:0] of environment register 1, and statusWord[12:11] equals bits [1:0] of environment register 6.
- R9: Idle cycles between the words of one packet do not change the packet, and outValid stays 0 until its last word is accepted.
- R10: If a polyline fills all DEPTH buffer slots without a terminator, overflowPulse is 1 for exactly one cycle and the buffered words are discarded. The next word starts a new packet.
- R11: inReady is 0 while a packet is being emitted. While outReady is 0, outValid, outData and the packet fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word present |
| inData | input | 32 | Input command word |
| inReady | output | 1 | Word will be accepted at this edge |
| outValid | output | 1 | Packet word present |
| outReady | input | 1 | Back end takes the packet word |
| outData | output | 32 | Packet word |
| outFirst | output | 1 | Word is the packet header |
| outLast | output | 1 | Word ends the packet |
| outOpcode | output | 8 | Opcode of the packet |
| outLen | output | 5 | Packet length in words |
| outKind | output | 2 | 0 draw, 1 image transfer, 2 memory copy |
| overflowPulse | output | 1 | One-cycle pulse: runaway polyline discarded |
| statusWord | output | 13 | Status bits mirrored from environment registers |
| envSel | input | 3 | Environment register select |
| envData | output | 32 | Selected environment register |

## Verification
The hardest case to reach from the ports is the buffer-full overflow. It needs a polyline header followed by exactly DEPTH-1 words, none of which may match the sentinel at an eligible index. The bench builds that sequence with vertex words whose top nibbles are not 5, watches that nothing is emitted along the way, and checks the single-cycle pulse. It then sends a one-word packet to show that the discarded words left no trace. The shaded sentinel rule is reached in a similar way: a matching word is placed at an odd index, and the bench shows that the packet only closes at the next even match.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  typedef enum logic { ST_COLLECT, ST_EMIT } stateT;
  typedef enum logic [1:0] { KIND_DRAW = 2'd0, KIND_XFER = 2'd1, KIND_COPY = 2'd2 } kindT;
  typedef enum logic [1:0] { POLY_NONE = 2'd0, POLY_FLAT = 2'd1, POLY_SHADED = 2'd2 } polyT;

  // control -> datapath strobes
  typedef struct packed {
    logic bufWr;
    logic envWr;
  } strobeT;

  // words after the header, per opcode
  function automatic logic [3:0] paramCount(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    case (op[7:5])
      3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
      3'b001: begin
        case (op[4:2])
          3'd0: n = 4'd3;
          3'd1: n = 4'd6;
          3'd2: n = 4'd4;
          3'd3: n = 4'd8;
          3'd4: n = 4'd5;
          3'd5: n = 4'd8;
          3'd6: n = 4'd7;
          default: n = 4'd11;
        endcase
      end
      3'b010: begin
        case (op[4:3])
          2'd0: n = 4'd2;
          2'd1: n = 4'd3;
          2'd2: n = 4'd3;
          default: n = 4'd4;
        endcase
      end
      3'b011: begin
        case (op[4:2])
          3'd0: n = 4'd2;
          3'd1: n = 4'd3;
          3'd2: n = 4'd1;
          3'd3: n = 4'd0;
          3'd4: n = 4'd1;
          3'd5: n = 4'd2;
          3'd6: n = 4'd1;
          default: n = 4'd2;
        endcase
      end
      3'b100: n = 4'd3;
      3'b101, 3'b110: n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic kindT kindOf(input logic [7:0] op);
    if (op[7:5] == 3'b100) return KIND_COPY;
    if (op >= 8'hA0 && op <= 8'hDF) return KIND_XFER;
    return KIND_DRAW;
  endfunction

  function automatic logic isSentinel(input logic [31:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

endpackage

// File: rtl/cmd_framer_ctrl.sv
module cmd_framer_ctrl
  import cmd_framer_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     inData,
  output logic            inReady,
  output logic            outValid,
  input  logic            outReady,
  output logic            outFirst,
  output logic            outLast,
  output logic [7:0]      outOpcode,
  output logic [LENW-1:0] outLen,
  output logic [1:0]      outKind,
  output logic            overflowPulse,
  output strobeT          strobe,
  output logic [IDXW-1:0] wrIdx,
  output logic [IDXW-1:0] rdIdx
);

  stateT           state;
  kindT            kind;
  polyT            poly;
  logic [LENW-1:0] count;
  logic [LENW-1:0] needLen;
  logic [7:0]      opcode;

  logic            accept, isHdr, hdrEnv, hdrNop, termHit, done, overflowHit;
  logic [7:0]      hdrOp;
  logic [LENW-1:0] hdrLen;
  polyT            hdrPoly;

  always_comb begin
    inReady = (state == ST_COLLECT);
    accept  = inValid && inReady;
    hdrOp   = inData[31:24];
    isHdr   = (count == '0);
    hdrEnv  = (hdrOp[7:3] == 5'b11100);
    hdrNop  = (hdrOp == 8'h1F);
    hdrLen  = LENW'(paramCount(hdrOp)) + LENW'(1);
    if (hdrOp[7:3] == 5'b01001)      hdrPoly = POLY_FLAT;
    else if (hdrOp[7:3] == 5'b01011) hdrPoly = POLY_SHADED;
    else                             hdrPoly = POLY_NONE;
    termHit = isSentinel(inData) &&
              ((poly == POLY_FLAT && count >= LENW'(3)) ||
               (poly == POLY_SHADED && count >= LENW'(4) && !count[0]));
    if (isHdr)                 done = !hdrEnv && !hdrNop && hdrPoly == POLY_NONE && hdrLen == LENW'(1);
    else if (poly != POLY_NONE) done = termHit;
    else                        done = (count + LENW'(1) == needLen);
    overflowHit   = !isHdr && poly != POLY_NONE && !termHit && count == LENW'(DEPTH - 1);
    strobe.bufWr  = accept && !(isHdr && (hdrEnv || hdrNop));
    strobe.envWr  = accept && isHdr && hdrEnv;
    wrIdx         = count[IDXW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_COLLECT;
      kind          <= KIND_DRAW;
      poly          <= POLY_NONE;
      count         <= '0;
      needLen       <= '0;
      opcode        <= '0;
      rdIdx         <= '0;
      overflowPulse <= 1'b0;
    end else begin
      overflowPulse <= accept && overflowHit;
      if (state == ST_COLLECT) begin
        if (accept) begin
          if (isHdr) begin
            opcode  <= hdrOp;
            needLen <= hdrLen;
            poly    <= hdrPoly;
            kind    <= kindOf(hdrOp);
          end
          if (isHdr && (hdrEnv || hdrNop)) begin
            count <= '0;
          end else if (overflowHit) begin
            count <= '0;
          end else if (done) begin
            state <= ST_EMIT;
            count <= count + LENW'(1);
            rdIdx <= '0;
          end else begin
            count <= count + LENW'(1);
          end
        end
      end else if (outReady) begin
        if (LENW'(rdIdx) == count - LENW'(1)) begin
          state <= ST_COLLECT;
          count <= '0;
        end else begin
          rdIdx <= rdIdx + IDXW'(1);
        end
      end
    end
  end

  assign outValid  = (state == ST_EMIT);
  assign outFirst  = (rdIdx == '0);
  assign outLast   = (LENW'(rdIdx) == count - LENW'(1));
  assign outOpcode = opcode;
  assign outLen    = count;
  assign outKind   = kind;

  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outOpcode) && $stable(outLen) && $stable(outKind));
  p_no_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
  p_len_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outLen >= LENW'(1) && outLen <= LENW'(DEPTH));
  p_copy_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind == 2'd2 |-> outLen == LENW'(4));
  p_ovf_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> !outValid && inReady);

endmodule

// File: rtl/cmd_framer_dp.sv
module cmd_framer_dp
  import cmd_framer_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int NENV = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     inData,
  input  strobeT          strobe,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [IDXW-1:0] rdIdx,
  output logic [31:0]     outData,
  output logic [12:0]     statusWord,
  input  logic [2:0]      envSel,
  output logic [31:0]     envData
);

  logic [31:0] mem [DEPTH];
  logic [31:0] envReg [NENV];

  always_ff @(posedge clk) begin
    if (strobe.bufWr) mem[wrIdx] <= inData;
  end

  for (genvar i = 0; i < NENV; i++) begin : g_env
    always_ff @(posedge clk) begin
      if (!rstN)
        envReg[i] <= {8'hE0 + 8'(i), 24'h0};
      else if (strobe.envWr && inData[26:24] == 3'(i))
        envReg[i] <= inData;
    end
  end

  assign outData    = mem[rdIdx];
  assign statusWord = {envReg[6][1:0], envReg[1][10:0]};
  assign envData    = envReg[envSel];

  p_status_env1_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.envWr && inData[26:24] == 3'd1 |=> statusWord[10:0] == $past(inData[10:0]));
  p_status_env6_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.envWr && inData[26:24] == 3'd6 |=> statusWord[12:11] == $past(inData[1:0]));
  p_env_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.envWr && strobe.bufWr));

endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
  import cmd_framer_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     inData,
  output logic            inReady,
  output logic            outValid,
  input  logic            outReady,
  output logic [31:0]     outData,
  output logic            outFirst,
  output logic            outLast,
  output logic [7:0]      outOpcode,
  output logic [LENW-1:0] outLen,
  output logic [1:0]      outKind,
  output logic            overflowPulse,
  output logic [12:0]     statusWord,
  input  logic [2:0]      envSel,
  output logic [31:0]     envData
);

  strobeT          strobe;
  logic [IDXW-1:0] wrIdx;
  logic [IDXW-1:0] rdIdx;

  cmd_framer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outFirst(outFirst), .outLast(outLast),
    .outOpcode(outOpcode), .outLen(outLen), .outKind(outKind),
    .overflowPulse(overflowPulse), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  cmd_framer_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .outData(outData), .statusWord(statusWord),
    .envSel(envSel), .envData(envData)
  );

  p_hdr_opcode_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFirst |-> outData[31:24] == outOpcode);
  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));

endmodule

// File: tb/cmd_packet_framer_tb.sv
module cmd_packet_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 0, rstN = 0, inValid = 0, outReady = 0;
  logic [31:0] inData = '0;
  logic [2:0]  envSel = '0;
  logic        inReady, outValid, outFirst, outLast, overflowPulse;
  logic [31:0] outData, envData;
  logic [7:0]  outOpcode;
  logic [4:0]  outLen;
  logic [1:0]  outKind;
  logic [12:0] statusWord;

  int nVec = 0, nBad = 0;
  logic [31:0] exp [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_packet_framer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outFirst(outFirst),
    .outLast(outLast), .outOpcode(outOpcode), .outLen(outLen), .outKind(outKind),
    .overflowPulse(overflowPulse), .statusWord(statusWord), .envSel(envSel), .envData(envData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // drive one word, return at the negedge after it was taken
  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    inValid = 1; inData = w;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic sendAll(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      sendWord(exp[i]);
      if (i < n - 1) chk(outValid == 0, tag, 32'(outValid), 32'd0);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic recvPacket(input int n, input logic [7:0] op, input logic [1:0] kd, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(outValid == 1, tag, 32'(outValid), 32'd1);
      chk(outData == exp[i], tag, outData, exp[i]);
      chk(outFirst == (i == 0) && outLast == (i == n - 1), tag, {outFirst, outLast}, {(i == 0), (i == n - 1)});
      if (i == 0) begin
        chk(outOpcode == op, tag, 32'(outOpcode), 32'(op));
        chk(outLen == 5'(n), tag, 32'(outLen), 32'(n));
        chk(outKind == kd, tag, 32'(outKind), 32'(kd));
      end
      outReady = 1;
      @(posedge clk);
      @(negedge clk);
      outReady = 0;
    end
    chk(outValid == 0 && inReady == 1, tag, {outValid, inReady}, 32'b01);
  endtask

  task automatic fixedPacket(input logic [7:0] op, input int n, input logic [1:0] kd, input string tag);
    exp[0] = {op, 24'h123456};
    for (int i = 1; i < n; i++) exp[i] = 32'h0100_0000 * i + 32'h0000_0A00 + i;
    sendAll(n, 0, tag);
    recvPacket(n, op, kd, tag);
  endtask

  task automatic t_reset;
    chk(inReady == 1 && outValid == 0 && overflowPulse == 0, "R1 handshake", {inReady, outValid, overflowPulse}, 32'b100);
    chk(statusWord == 0, "R1 status", 32'(statusWord), 32'd0);
    for (int i = 0; i < 8; i++) begin
      envSel = 3'(i);
      #1;
      chk(envData == {8'hE0 + 8'(i), 24'h0}, "R1 env", envData, {8'hE0 + 8'(i), 24'h0});
    end
    envSel = 0;
  endtask

  task automatic t_fixed;
    fixedPacket(8'h00, 1, 2'd0, "R2 op00");
    fixedPacket(8'h02, 3, 2'd0, "R2 op02");
    fixedPacket(8'h20, 4, 2'd0, "R2 op20");
    fixedPacket(8'h24, 7, 2'd0, "R2 op24");
    fixedPacket(8'h2C, 9, 2'd0, "R2 op2C");
    fixedPacket(8'h3C, 12, 2'd0, "R2 op3C");
    fixedPacket(8'h64, 4, 2'd0, "R2 op64");
  endtask

  task automatic t_kinds;
    fixedPacket(8'h80, 4, 2'd2, "R3 copy80");
    fixedPacket(8'h9F, 4, 2'd2, "R3 copy9F");
    fixedPacket(8'hA0, 3, 2'd1, "R3 xferA0");
    fixedPacket(8'hDF, 3, 2'd1, "R3 xferDF");
  endtask

  task automatic t_flat;
    // sentinel at index 2 ignored, at index 3 ends
    exp[0] = 32'h4800_00FF; exp[1] = 32'h0010_0020; exp[2] = 32'h5000_5000;
    exp[3] = 32'h5555_5555;
    sendAll(4, 0, "R4 flat short");
    recvPacket(4, 8'h48, 2'd0, "R4 flat short");
    exp[0] = 32'h4F00_0000; exp[1] = 32'h0001_0001; exp[2] = 32'h0002_0002;
    exp[3] = 32'h0003_0003; exp[4] = 32'h0004_0004; exp[5] = 32'h5AB5_5CD5;
    sendAll(6, 0, "R4 flat long");
    recvPacket(6, 8'h4F, 2'd0, "R4 flat long");
  endtask

  task automatic t_shaded;
    // sentinel at odd index 5 is data; closes at index 6
    exp[0] = 32'h5800_0011; exp[1] = 32'h0001_0001; exp[2] = 32'h0000_0022;
    exp[3] = 32'h0002_0002; exp[4] = 32'h0000_0033; exp[5] = 32'h5000_5000;
    exp[6] = 32'h5000_5000;
    sendAll(7, 0, "R5 shaded");
    recvPacket(7, 8'h58, 2'd0, "R5 shaded");
  endtask

  task automatic t_env;
    sendWord(32'hE1FF_F5A5);
    chk(outValid == 0 && inReady == 1, "R6 not emitted", {outValid, inReady}, 32'b01);
    sendWord(32'hE600_0003);
    sendWord(32'hE3AB_CDEF);
    chk(outValid == 0, "R6 not emitted", 32'(outValid), 32'd0);
    envSel = 3'd1; #1;
    chk(envData == 32'hE1FF_F5A5, "R6 env1", envData, 32'hE1FF_F5A5);
    envSel = 3'd3; #1;
    chk(envData == 32'hE3AB_CDEF, "R6 env3", envData, 32'hE3AB_CDEF);
    envSel = 3'd2; #1;
    chk(envData == 32'hE200_0000, "R6 env2 untouched", envData, 32'hE200_0000);
    chk(statusWord == 13'h1DA5, "R8 status", 32'(statusWord), 32'h1DA5);
  endtask

  task automatic t_nop;
    sendWord(32'h1F12_3456);
    chk(outValid == 0 && inReady == 1, "R7 nop", {outValid, inReady}, 32'b01);
    exp[0] = 32'h0100_0000;
    sendAll(1, 0, "R7 next");
    recvPacket(1, 8'h01, 2'd0, "R7 next");
  endtask

  task automatic t_gaps;
    exp[0] = 32'h2800_0007;
    for (int i = 1; i < 5; i++) exp[i] = 32'h00C0_0000 + i;
    sendAll(5, 3, "R9 gaps");
    recvPacket(5, 8'h28, 2'd0, "R9 gaps");
  endtask

  task automatic t_overflow;
    sendWord(32'h4800_0000);
    for (int i = 1; i < DEPTH; i++) begin
      chk(overflowPulse == 0 && outValid == 0, "R10 pre", {overflowPulse, outValid}, 32'd0);
      sendWord(32'h0001_0001 * i);
    end
    chk(overflowPulse == 1, "R10 pulse", 32'(overflowPulse), 32'd1);
    @(negedge clk);
    chk(overflowPulse == 0 && outValid == 0, "R10 pulse once", {overflowPulse, outValid}, 32'd0);
    exp[0] = 32'h0300_0000;
    sendAll(1, 0, "R10 after");
    recvPacket(1, 8'h03, 2'd0, "R10 after");
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    exp[0] = 32'h8000_0001; exp[1] = 32'h1111_1111; exp[2] = 32'h2222_2222; exp[3] = 32'h3333_3333;
    sendAll(4, 0, "R11 bp");
    held = outData;
    for (int i = 0; i < 3; i++) begin
      inValid = 1; inData = 32'h0000_0000;
      @(negedge clk);
      chk(inReady == 0 && outValid == 1 && outData == held, "R11 hold", outData, held);
    end
    inValid = 0;
    recvPacket(4, 8'h80, 2'd2, "R11 bp");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_kinds();
    t_flat();
    t_shaded();
    t_env();
    t_nop();
    t_gaps();
    t_overflow();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule